// File: doc/BRIEF.md
# Loss-of-Signal Qualifier

This block sits between a receive line's analog level detector and the line decoder. Each recovered receive clock, the detector reports whether the incoming signal is below the usable amplitude. The qualifier turns that raw, noisy per-clock indication into a stable active-low loss flag that changes only when a condition persists. The same count of receive clocks applies in both directions, which gives the flag hysteresis.

A transition is pending whenever a sample disagrees with the present flag state. That means a below-threshold sample while the link is good, or a valid sample while the link is lost. A run of consecutive pending samples equal to the qualification count flips the state. Any sample that agrees with the present state ends the run, and the count starts again from zero.

The block also drives a squelch enable to the decoder. It gates the two receive data rails, so nothing reaches the decoder while loss is flagged. After reset the flag reports loss until the first valid qualification completes.

Top module: `los_qualifier`

## Requirements
- R1: During reset and after it, `los_n_o` is 0 (loss), `squelch_o` is 1 and both rail outputs are 0, until a qualification completes.
- R2: While loss is flagged, `QUAL_CNT` (default 175) consecutive samples with `below_thr_i`=0 set `los_n_o` to 1 right after the clock edge that captures the last of them. `QUAL_CNT`-1 such samples leave it at 0.
- R3: While the link is good, `QUAL_CNT` consecutive samples with `below_thr_i`=1 clear `los_n_o` to 0 right after the edge that captures the last of them. `QUAL_CNT`-1 such samples leave it at 1.
- R4: A single sample that agrees with the present state restarts the pending run from zero. After that, a full `QUAL_CNT` further pending samples are needed, and the internal run count never reaches `QUAL_CNT`.
- R5: While `los_n_o` is 0, `rx_pos_o` and `rx_neg_o` are 0 whatever the rail inputs are. While it is 1, the rail outputs equal the rail inputs in the same cycle.
- R6: `squelch_o` is always the inverse of `los_n_o`.
- R7: Samples that agree with the present state, however many there are, never change `los_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| below_thr_i | input | 1 | Level detector: 1 = input below minimum level this clock |
| rx_pos_i | input | 1 | Positive receive rail from the slicer |
| rx_neg_i | input | 1 | Negative receive rail from the slicer |
| los_n_o | output | 1 | Loss-of-signal flag, 0 = loss |
| squelch_o | output | 1 | Squelch enable to the decoder, 1 = squelch |
| rx_pos_o | output | 1 | Positive rail after squelch |
| rx_neg_o | output | 1 | Negative rail after squelch |

## Verification
Directed runs of exactly one sample fewer than the qualification count, and of exactly that count, separate a correct threshold from an off-by-one in either direction. Runs of one short of the count, broken by a single agreeing sample, show whether the counter really restarts rather than pausing. Long runs of agreeing samples in each state show that those samples have no effect. Random runs of 1 to 260 samples, with random rail data, mix short glitches that must be ignored with long runs that must flip the state. Across all of these, the rail gating and the squelch output are compared every cycle.

// File: rtl/los_qual_pkg.sv
package los_qual_pkg;
  typedef enum logic {
    LINK_LOST = 1'b0,
    LINK_OK   = 1'b1
  } link_st_e;
endpackage

// File: rtl/los_persist_cnt.sv
module los_persist_cnt #(
  parameter int QUAL_CNT = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  output logic done_o
);
  localparam int CNT_W = (QUAL_CNT < 2) ? 1 : $clog2(QUAL_CNT);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(QUAL_CNT - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done_o = pending_i && (cnt_q == LAST);
  assign cnt_en = pending_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!pending_i)           cnt_d = '0;
    else if (done_o)          cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < QUAL_CNT);

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_i |=> cnt_q == '0);
endmodule

// File: rtl/los_state_reg.sv
module los_state_reg
  import los_qual_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic below_thr_i,
  input  logic done_i,
  output logic pending_o,
  output logic los_n_o
);
  link_st_e link_q, link_d;

  assign pending_o = (link_q == LINK_OK) ? below_thr_i : ~below_thr_i;

  always_comb begin
    link_d = link_q;
    if (done_i) link_d = (link_q == LINK_OK) ? LINK_LOST : LINK_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      link_q <= LINK_LOST;
    else if (done_i) link_q <= link_d;
  end

  assign los_n_o = (link_q == LINK_OK);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_o |=> $stable(los_n_o));

  assert_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_n_o) |-> $past(!below_thr_i));

  assert_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_n_o) |-> $past(below_thr_i));
endmodule

// File: rtl/los_rx_gate.sv
module los_rx_gate (
  input  logic los_n_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  output logic squelch_o,
  output logic rx_pos_o,
  output logic rx_neg_o
);
  assign squelch_o = ~los_n_i;
  assign rx_pos_o  = rx_pos_i & los_n_i;
  assign rx_neg_o  = rx_neg_i & los_n_i;
endmodule

// File: rtl/los_qualifier.sv
module los_qualifier #(
  parameter int QUAL_CNT = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_thr_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  output logic los_n_o,
  output logic squelch_o,
  output logic rx_pos_o,
  output logic rx_neg_o
);
  logic rst_meta_q, rst_sync_n;
  logic pending, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  los_state_reg u_state (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .below_thr_i (below_thr_i),
    .done_i      (done),
    .pending_o   (pending),
    .los_n_o     (los_n_o)
  );

  los_persist_cnt #(.QUAL_CNT(QUAL_CNT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pending_i (pending),
    .done_o    (done)
  );

  los_rx_gate u_gate (
    .los_n_i   (los_n_o),
    .rx_pos_i  (rx_pos_i),
    .rx_neg_i  (rx_neg_i),
    .squelch_o (squelch_o),
    .rx_pos_o  (rx_pos_o),
    .rx_neg_o  (rx_neg_o)
  );

  assert_squelch_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    squelch_o != los_n_o);

  assert_rails_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !los_n_o |-> !(rx_pos_o || rx_neg_o));
endmodule

// File: tb/los_qualifier_tb.sv
`timescale 1ns/1ps
module los_qualifier_tb;
  localparam int Q = 175;

  logic clk = 1'b0;
  logic rst_n;
  logic below, pos, neg;
  logic los_n_o, squelch_o, rx_pos_o, rx_neg_o;

  int tests = 0;
  int fails = 0;
  bit model_ok = 1'b0;
  int model_cnt = 0;

  always #2.5 clk = ~clk;

  los_qualifier #(.QUAL_CNT(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .below_thr_i(below),
    .rx_pos_i(pos), .rx_neg_i(neg),
    .los_n_o(los_n_o), .squelch_o(squelch_o),
    .rx_pos_o(rx_pos_o), .rx_neg_o(rx_neg_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit next_ok(input bit ok, input bit b, inout int cnt);
    bit pend;
    pend = ok ? b : !b;
    if (!pend) begin
      cnt = 0;
      return ok;
    end
    cnt++;
    if (cnt == Q) begin
      cnt = 0;
      return !ok;
    end
    return ok;
  endfunction

  task automatic cyc(input logic b, input string tag);
    @(negedge clk);
    below = b;
    pos = 1'($urandom % 2);
    neg = pos ? 1'b0 : 1'($urandom % 2);
    #0.5;
    chk(los_n_o, model_ok, tag);
    chk(squelch_o, !model_ok, "R6");
    chk(rx_pos_o, model_ok ? pos : 1'b0, "R5");
    chk(rx_neg_o, model_ok ? neg : 1'b0, "R5");
    model_ok = next_ok(model_ok, b, model_cnt);
  endtask

  initial begin
    void'($urandom(32'd20241));
    rst_n = 1'b0; below = 1'b1; pos = 1'b1; neg = 1'b0;
    repeat (3) @(negedge clk);
    #0.5;
    chk(los_n_o, 1'b0, "R1");
    chk(squelch_o, 1'b1, "R1");
    chk(rx_pos_o, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) cyc(1'b1, "R1");
    // R2: one short keeps loss, exact count clears it
    repeat (Q - 1) cyc(1'b0, "R2");
    cyc(1'b0, "R2");
    cyc(1'b0, "R2");
    chk(los_n_o, 1'b1, "R2");
    // R4: restart after a single agreeing sample
    repeat (Q - 1) cyc(1'b1, "R4");
    cyc(1'b0, "R4");
    repeat (Q - 1) cyc(1'b1, "R4");
    cyc(1'b0, "R4");
    chk(los_n_o, 1'b1, "R4");
    // R3: exact count of below samples asserts loss
    repeat (Q) cyc(1'b1, "R3");
    cyc(1'b1, "R3");
    chk(los_n_o, 1'b0, "R3");
    // R7: agreeing samples in loss state
    repeat (300) cyc(1'b1, "R7");
    chk(los_n_o, 1'b0, "R7");
    repeat (Q) cyc(1'b0, "R2");
    repeat (300) cyc(1'b0, "R7");
    chk(los_n_o, 1'b1, "R7");
    // random runs
    for (int r = 0; r < 40; r++) begin
      logic v;
      int len;
      v = 1'($urandom % 2);
      len = 1 + int'($urandom % 260);
      for (int k = 0; k < len; k++) cyc(v, "R2 R3");
    end
    cyc(1'b0, "R2 R3");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule